// File: doc/BRIEF.md
# Fault-Tolerant Cache Block Remapper

This block sits between the row/column address decode of a cache and its column multiplexer. Every cache row holds four blocks, picked by a 2-bit column code. Before normal operation, a built-in self-test loads a small per-row table. The table holds a 2-bit physical block index for each of the four logical column codes. During normal operation the table drives the column select, so an access to a block that was found faulty lands on a healthy block in the same row. Aliased codes then share one physical block, which shrinks the usable cache. Nothing is visible to the processor, and no cycle is added: the lookup is purely combinational.

There are two ways to load a row. The tester can write a raw 8-bit map, or it can write a 4-bit fault vector. From a fault vector the block computes the map itself: each faulty block is redirected to the nearest healthy block with a higher index, wrapping from 3 back to 0. When a row has no healthy block, it is flagged dead, and accesses to it are reported as not cacheable.

A two-state controller gates all writes. In `ST_RUN` the table is frozen. The `GO_CFG` transition, taken when `cfg_mode` is sampled high, enters `ST_CFG`. In `ST_CFG` writes are accepted. The `GO_RUN` transition, taken when `cfg_mode` is sampled low, returns to `ST_RUN`.

Top module: `cbr_remapper`

## Requirements
- R1: After reset, every row maps column code c to block c, no row is dead, and `cfg_active` is 0.
- R2: `sel_col`, `row_dead` and `acc_cacheable` follow `acc_row`/`acc_col`/`acc_valid` combinationally in the same cycle.
- R3: In `ST_CFG`, a raw write (`cfg_we`=1, `cfg_fv_we`=0) stores `cfg_map` for row `cfg_row`. Column c takes bits `cfg_map[2c+1:2c]`. The write clears that row's dead flag and is visible from the next cycle.
- R4: In `ST_CFG`, a fault-vector write (`cfg_fv_we`=1; bit i=1 means block i is faulty) maps each healthy block to itself. Each faulty block goes to the first healthy block among i+1, i+2, i+3 (mod 4).
- R5: A fault vector of 4'b1111 sets the row's dead flag and stores the identity map. While a dead row is addressed, `row_dead`=1 and `acc_cacheable`=0.
- R6: In `ST_RUN`, `cfg_we` and `cfg_fv_we` have no effect on any row.
- R7: `cfg_active` is 1 in the cycle after `cfg_mode` is sampled 1 and 0 in the cycle after it is sampled 0.
- R8: When `cfg_we` and `cfg_fv_we` are both 1, the fault-vector write wins.
- R9: A write changes only the row named by `cfg_row`.
- R10: `acc_cacheable` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Request for configuration state |
| cfg_we | input | 1 | Raw map write strobe |
| cfg_fv_we | input | 1 | Fault-vector write strobe |
| cfg_row | input | ROW_W | Row being written |
| cfg_map | input | 8 | Raw map, 2 bits per column code |
| cfg_fault | input | 4 | Per-block fault vector, bit i = block i |
| acc_valid | input | 1 | Access present |
| acc_row | input | ROW_W | Access row |
| acc_col | input | 2 | Logical column code of the access |
| sel_col | output | 2 | Physical block select to the column multiplexer |
| row_dead | output | 1 | Addressed row has no healthy block |
| acc_cacheable | output | 1 | Access may be served from the cache |
| cfg_active | output | 1 | Controller is in `ST_CFG` |

## Verification
The bench loads several fault vectors to exercise the corner cases:
- faulty block 0, where a design without redirection would keep selecting block 0;
- faulty block 3, where a design without wraparound would pick a nonexistent or faulty block instead of block 0;
- three faulty blocks, where every code must collapse onto the single survivor;
- all four blocks faulty, where a missing dead flag would let the access through as cacheable.

It also strobes writes while the controller is in `ST_RUN`, where a missing gate would corrupt the table. It raises both strobes together, where the wrong priority would store the raw map. It rewrites a dead row with a raw map, where a stale dead flag would persist. A cycle-level reference model is compared on every clock, which also catches a wrong neighbouring row or an off-by-one cycle in the controller.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int BLK_N = 4;
    localparam int COL_W = 2;

    typedef logic [COL_W-1:0] col_t;
    typedef col_t [BLK_N-1:0] rowmap_t;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } cfg_state_e;

    function automatic rowmap_t identity_map();
        rowmap_t m;
        for (int i = 0; i < BLK_N; i++) begin
            m[i] = col_t'(i);
        end
        return m;
    endfunction
endpackage

// File: rtl/cbr_cfg_ctrl.sv
module cbr_cfg_ctrl
    import cbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_mode,
    output logic cfg_active,
    output logic wr_ok
);
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (cfg_mode)  state_d = ST_CFG;   // GO_CFG
            ST_CFG: if (!cfg_mode) state_d = ST_RUN;   // GO_RUN
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_active = 1'b0;
        wr_ok      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cfg_active = 1'b0;
                wr_ok      = 1'b0;
            end
            ST_CFG: begin
                cfg_active = 1'b1;
                wr_ok      = 1'b1;
            end
            default: begin
                cfg_active = 1'b0;
                wr_ok      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cbr_remap_calc.sv
module cbr_remap_calc
    import cbr_pkg::*;
(
    input  logic [BLK_N-1:0] fault,
    output rowmap_t          map,
    output logic             dead
);
    assign dead = &fault;

    for (genvar gi = 0; gi < BLK_N; gi++) begin : g_blk
        always_comb begin
            logic found;
            found      = 1'b0;
            map[gi]    = col_t'(gi);
            if (fault[gi]) begin
                for (int k = 1; k < BLK_N; k++) begin
                    if (!found && !fault[(gi + k) % BLK_N]) begin
                        map[gi] = col_t'((gi + k) % BLK_N);
                        found   = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cbr_map_store.sv
module cbr_map_store
    import cbr_pkg::*;
#(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  rowmap_t           wr_map,
    input  logic              wr_dead,
    input  logic [ROW_W-1:0]  rd_row,
    output rowmap_t           rd_map,
    output logic              rd_dead,
    output rowmap_t [ROWS-1:0] all_map,
    output logic [ROWS-1:0]   dead_vec
);
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                all_map[gr]  <= identity_map();
                dead_vec[gr] <= 1'b0;
            end else if (wr_en && (wr_row == ROW_W'(gr))) begin
                all_map[gr]  <= wr_map;
                dead_vec[gr] <= wr_dead;
            end
        end
    end

    assign rd_map  = all_map[rd_row];
    assign rd_dead = dead_vec[rd_row];
endmodule

// File: rtl/cbr_remapper.sv
module cbr_remapper
    import cbr_pkg::*;
#(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W,
    localparam int MAP_W = BLK_N * COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_we,
    input  logic             cfg_fv_we,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic [MAP_W-1:0] cfg_map,
    input  logic [BLK_N-1:0] cfg_fault,
    input  logic             acc_valid,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    output logic [COL_W-1:0] sel_col,
    output logic             row_dead,
    output logic             acc_cacheable,
    output logic             cfg_active
);
    logic                wr_ok;
    rowmap_t             calc_map;
    logic                calc_dead;
    rowmap_t             wr_map;
    logic                wr_dead;
    logic                wr_en;
    rowmap_t             rd_map;
    logic                rd_dead;
    rowmap_t [ROWS-1:0]  all_map;
    logic [ROWS-1:0]     dead_vec;
    logic [ROWS*MAP_W-1:0] store_flat;

    cbr_cfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_active (cfg_active),
        .wr_ok      (wr_ok)
    );

    cbr_remap_calc u_calc (
        .fault (cfg_fault),
        .map   (calc_map),
        .dead  (calc_dead)
    );

    // fault-vector load has priority over a raw map load
    assign wr_en   = wr_ok && (cfg_we || cfg_fv_we);
    assign wr_map  = cfg_fv_we ? calc_map : rowmap_t'(cfg_map);
    assign wr_dead = cfg_fv_we && calc_dead;

    cbr_map_store #(.ROW_W(ROW_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_row   (cfg_row),
        .wr_map   (wr_map),
        .wr_dead  (wr_dead),
        .rd_row   (acc_row),
        .rd_map   (rd_map),
        .rd_dead  (rd_dead),
        .all_map  (all_map),
        .dead_vec (dead_vec)
    );

    assign store_flat    = all_map;
    assign sel_col       = rd_map[acc_col];
    assign row_dead      = rd_dead;
    assign acc_cacheable = acc_valid && !rd_dead;
endmodule

// File: rtl/cbr_remapper_chk.sv
module cbr_remapper_chk #(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_mode,
    input logic                cfg_active,
    input logic                acc_valid,
    input logic                row_dead,
    input logic                acc_cacheable,
    input logic [1:0]          sel_col,
    input logic [ROWS*8-1:0]   store_flat,
    input logic [ROWS-1:0]     dead_vec
);
    assert_enter_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> cfg_active);

    assert_leave_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> !cfg_active);

    assert_frozen_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> ($stable(store_flat) && $stable(dead_vec)));

    assert_dead_uncached_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_dead |-> !acc_cacheable);

    assert_idle_uncached_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_cacheable);

    assert_sel_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(sel_col));
endmodule

bind cbr_remapper cbr_remapper_chk #(.ROW_W(ROW_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_active    (cfg_active),
    .acc_valid     (acc_valid),
    .row_dead      (row_dead),
    .acc_cacheable (acc_cacheable),
    .sel_col       (sel_col),
    .store_flat    (store_flat),
    .dead_vec      (dead_vec)
);

// File: tb/cbr_remapper_bench.sv
`timescale 1ns/1ps
module cbr_remapper_bench;
    localparam int PERIOD = 10;
    localparam int ROW_W  = 4;
    localparam int ROWS   = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode = 1'b0, cfg_we = 1'b0, cfg_fv_we = 1'b0;
    logic [ROW_W-1:0] cfg_row = '0;
    logic [7:0] cfg_map = '0;
    logic [3:0] cfg_fault = '0;
    logic acc_valid = 1'b0;
    logic [ROW_W-1:0] acc_row = '0;
    logic [1:0] acc_col = '0;
    logic [1:0] sel_col;
    logic row_dead, acc_cacheable, cfg_active;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_map [ROWS][4];
    bit m_dead [ROWS];
    bit m_cfg;

    always #(PERIOD/2) clk = ~clk;

    cbr_remapper #(.ROW_W(ROW_W)) u_cbr_remapper (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_fv_we(cfg_fv_we), .cfg_row(cfg_row), .cfg_map(cfg_map),
        .cfg_fault(cfg_fault), .acc_valid(acc_valid), .acc_row(acc_row),
        .acc_col(acc_col), .sel_col(sel_col), .row_dead(row_dead),
        .acc_cacheable(acc_cacheable), .cfg_active(cfg_active)
    );

    task automatic model_reset();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < 4; c++) m_map[r][c] = c;
            m_dead[r] = 0;
        end
        m_cfg = 0;
    endtask

    initial model_reset();

    // reference model: state changes at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (m_cfg && cfg_fv_we) begin
                int r;
                r = int'(cfg_row);
                m_dead[r] = (cfg_fault == 4'hF);
                for (int c = 0; c < 4; c++) begin
                    int pick;
                    pick = c;
                    if (cfg_fault[c] && cfg_fault != 4'hF) begin
                        int step;
                        step = 1;
                        while (cfg_fault[(c + step) % 4]) step++;
                        pick = (c + step) % 4;
                    end
                    m_map[r][c] = pick;
                end
            end else if (m_cfg && cfg_we) begin
                for (int c = 0; c < 4; c++) m_map[int'(cfg_row)][c] = int'(cfg_map[2*c +: 2]);
                m_dead[int'(cfg_row)] = 0;
            end
            m_cfg = cfg_mode;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, a quarter period after the falling edge
    always @(negedge clk) begin
        #(PERIOD/4);
        if (rst_n && !finished) begin
            int exp_sel;
            bit exp_dead;
            exp_sel  = m_map[int'(acc_row)][int'(acc_col)];
            exp_dead = m_dead[int'(acc_row)];
            check(int'(sel_col) == exp_sel, "R2 sel_col", int'(sel_col), exp_sel);
            check(row_dead == exp_dead, "R5 row_dead", int'(row_dead), int'(exp_dead));
            check(acc_cacheable == (acc_valid && !exp_dead), "R10 acc_cacheable",
                  int'(acc_cacheable), int'(acc_valid && !exp_dead));
            check(cfg_active == m_cfg, "R7 cfg_active", int'(cfg_active), int'(m_cfg));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic probe(input int row, input int col, input int exp, input string req);
        acc_row = ROW_W'(row);
        acc_col = 2'(col);
        #1;
        check(int'(sel_col) == exp, req, int'(sel_col), exp);
    endtask

    task automatic wr_fault(input int row, input logic [3:0] f);
        step();
        cfg_row = ROW_W'(row); cfg_fault = f; cfg_fv_we = 1'b1; cfg_we = 1'b0;
        step();
        cfg_fv_we = 1'b0;
    endtask

    task automatic wr_raw(input int row, input logic [7:0] m);
        step();
        cfg_row = ROW_W'(row); cfg_map = m; cfg_we = 1'b1; cfg_fv_we = 1'b0;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        acc_valid = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: identity after reset
        for (int r = 0; r < ROWS; r += 5) begin
            for (int c = 0; c < 4; c++) probe(r, c, c, "R1 identity");
        end
        check(cfg_active == 1'b0, "R1 cfg_active", int'(cfg_active), 0);
        check(row_dead == 1'b0, "R1 row_dead", int'(row_dead), 0);

        // R6: writes in run state ignored
        wr_raw(2, 8'hFF);
        wr_fault(2, 4'hF);
        step();
        for (int c = 0; c < 4; c++) probe(2, c, c, "R6 ignored in run");
        check(row_dead == 1'b0, "R6 dead unchanged", int'(row_dead), 0);

        // R7: enter config
        step(); cfg_mode = 1'b1;
        step(); #1;
        check(cfg_active == 1'b1, "R7 enter cfg", int'(cfg_active), 1);

        // R4: fault-vector loads
        wr_fault(3, 4'b0001);
        wr_fault(5, 4'b1010);
        wr_fault(6, 4'b0111);
        step();
        probe(3, 0, 1, "R4 row3 c0"); probe(3, 1, 1, "R4 row3 c1");
        probe(3, 2, 2, "R4 row3 c2"); probe(3, 3, 3, "R4 row3 c3");
        probe(5, 1, 2, "R4 row5 c1"); probe(5, 3, 0, "R4 wrap row5 c3");
        probe(5, 0, 0, "R4 row5 c0");
        probe(6, 0, 3, "R4 row6 c0"); probe(6, 2, 3, "R4 row6 c2");

        // R5: all faulty
        wr_fault(7, 4'hF);
        step();
        probe(7, 2, 2, "R5 identity dead row");
        check(row_dead == 1'b1, "R5 dead flag", int'(row_dead), 1);
        check(acc_cacheable == 1'b0, "R5 uncacheable", int'(acc_cacheable), 0);

        // R3: raw map, also clears dead
        wr_raw(8, 8'b00_01_10_11);
        wr_raw(7, 8'b11_10_01_00);
        step();
        probe(8, 0, 3, "R3 row8 c0"); probe(8, 1, 2, "R3 row8 c1");
        probe(8, 3, 0, "R3 row8 c3");
        probe(7, 1, 1, "R3 row7 c1");
        check(row_dead == 1'b0, "R3 dead cleared", int'(row_dead), 0);

        // R8: both strobes, fault vector wins
        step();
        cfg_row = 4'd9; cfg_map = 8'h00; cfg_fault = 4'b0010;
        cfg_we = 1'b1; cfg_fv_we = 1'b1;
        step();
        cfg_we = 1'b0; cfg_fv_we = 1'b0;
        step();
        probe(9, 1, 2, "R8 priority c1"); probe(9, 3, 3, "R8 priority c3");

        // R9: untouched row
        for (int c = 0; c < 4; c++) probe(4, c, c, "R9 other row");

        // R10: no access, not cacheable
        acc_row = 4'd4; acc_valid = 1'b0; #1;
        check(acc_cacheable == 1'b0, "R10 invalid", int'(acc_cacheable), 0);
        acc_valid = 1'b1;

        // R7 leave config, R6 frozen again
        step(); cfg_mode = 1'b0;
        step(); #1;
        check(cfg_active == 1'b0, "R7 leave cfg", int'(cfg_active), 0);
        wr_fault(3, 4'b0000);
        step();
        probe(3, 0, 1, "R6 frozen row3");

        repeat (2) step();
        finish_run();
    end
endmodule